// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This block supplies the data-hazard decisions for a five-stage in-order integer pipeline. Each cycle it looks at the source registers of the instructions in decode and execute. It compares them with the destinations that are still travelling through the two later pipeline registers: the execute/memory register and the memory/writeback register. From that comparison it drives the selects of the two ALU operand multiplexers. It also drives a select that lets a store in the memory stage take the loaded value straight from writeback.

When a load in execute produces a register that the instruction in decode needs as an ALU operand, forwarding cannot deliver the value in time. The block then raises a single stall signal for one cycle. While it is high, the surrounding pipeline holds its PC and fetch/decode register and loads a no-op, with its write enable cleared, into the decode/execute register.

The block also holds the architectural register file. The file has two read ports for decode and one write port fed by writeback. A write is visible to a read in the same cycle, and register 0 always reads as zero.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An ALU operand select (`fwd_a` for `ex_rs1`, `fwd_b` for `ex_rs2`) reads 2'b10 (EX/MEM result) when `mem_we` is 1, `mem_load` is 0, `mem_rd` is non-zero and `mem_rd` equals that operand's source.
- R2: An operand select reads 2'b01 (MEM/WB result) when `wb_we` is 1, `wb_rd` is non-zero and matches the source, and the EX/MEM stage does not hold a write (`mem_we` 1) to the same non-zero register. A newer EX/MEM match, including one from a load, takes precedence over MEM/WB.
- R3: A destination of register 0 never produces a forward (select stays 2'b00), never produces a store-data forward and never produces a stall.
- R4: A stage whose write enable is 0 never produces a forward, whatever its destination field holds.
- R5: When `wb_we` is 1 and `wb_rd` equals a non-zero read address, that read port returns `wb_data` in the same cycle.
- R6: A read of register 0 returns zero, even after a write to register 0 has been attempted.
- R7: `st_fwd` is 1 exactly when `mem_store` is 1, and `wb_we` and `wb_load` are both 1, and `wb_rd` is non-zero and equals `mem_rs2`.
- R8: `stall` is 1 when `ex_load` and `ex_we` are both 1 and `ex_rd` is non-zero, and either `ex_rd` equals `id_rs1` with `id_use1` set, or `ex_rd` equals `id_rs2` with `id_use2` set and `id_store` clear.
- R9: A store in decode whose only match with a load in execute is its data register (`id_rs2`) does not stall.
- R10: A load result held in EX/MEM (`mem_load` 1) is never forwarded to an ALU operand (select never 2'b10).
- R11: After reset every register reads zero, and a written value persists once the write enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the register file |
| id_rs1 | input | AW | First source of the decode instruction; read address 1 |
| id_rs2 | input | AW | Second source of the decode instruction; read address 2 |
| id_use1 | input | 1 | Decode instruction reads id_rs1 |
| id_use2 | input | 1 | Decode instruction reads id_rs2 |
| id_store | input | 1 | Decode instruction is a store (id_rs2 is store data only) |
| ex_rs1 | input | AW | First source of the execute instruction |
| ex_rs2 | input | AW | Second source of the execute instruction |
| ex_rd | input | AW | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination held in EX/MEM |
| mem_we | input | 1 | EX/MEM instruction writes a register |
| mem_load | input | 1 | EX/MEM instruction is a load |
| mem_store | input | 1 | EX/MEM instruction is a store |
| mem_rs2 | input | AW | Store-data source of the EX/MEM instruction |
| wb_rd | input | AW | Destination held in MEM/WB; write address |
| wb_we | input | 1 | MEM/WB instruction writes a register; write enable |
| wb_load | input | 1 | MEM/WB instruction is a load |
| wb_data | input | DW | Result in MEM/WB; write data |
| rd_data1 | output | DW | Read data for id_rs1 |
| rd_data2 | output | DW | Read data for id_rs2 |
| fwd_a | output | 2 | ALU operand A select: 00 file, 01 MEM/WB, 10 EX/MEM |
| fwd_b | output | 2 | ALU operand B select, same encoding |
| st_fwd | output | 1 | Memory-stage store data taken from MEM/WB |
| stall | output | 1 | Hold PC and IF/ID, insert bubble into ID/EX |

## Verification
Two functions can act on the same writeback in one cycle. The same-cycle register-file bypass feeds decode, and the MEM/WB forward feeds execute. The bench keeps one writeback active while decode reads that register and execute names it as a source. It judges both the read data and the operand select in that cycle. It then adds an EX/MEM writer to the same register, which must take the operand select without disturbing the bypassed read.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_store,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [AW-1:0] mem_rs2,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          wb_load,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] rd_data1,
  output logic [DW-1:0] rd_data2,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          st_fwd,
  output logic          stall
);

  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wb_we && wb_rd != '0) begin
      rf[wb_rd] <= wb_data;
    end
  end

  logic wb_hit1, wb_hit2;
  assign wb_hit1  = wb_we && wb_rd == id_rs1;
  assign wb_hit2  = wb_we && wb_rd == id_rs2;
  assign rd_data1 = (id_rs1 == '0) ? '0 : wb_hit1 ? wb_data : rf[id_rs1];
  assign rd_data2 = (id_rs2 == '0) ? '0 : wb_hit2 ? wb_data : rf[id_rs2];

  logic exm_live, exm_alu, mwb_live;
  assign exm_live = mem_we && mem_rd != '0;
  assign exm_alu  = exm_live && !mem_load;
  assign mwb_live = wb_we && wb_rd != '0;

  function automatic logic [1:0] pick(input logic [AW-1:0] src);
    if (exm_alu && mem_rd == src)                                  return 2'b10;
    else if (mwb_live && wb_rd == src && !(exm_live && mem_rd == src)) return 2'b01;
    else                                                           return 2'b00;
  endfunction

  assign fwd_a  = pick(ex_rs1);
  assign fwd_b  = pick(ex_rs2);
  assign st_fwd = mem_store && mwb_live && wb_load && wb_rd == mem_rs2;

  logic ld_live;
  assign ld_live = ex_load && ex_we && ex_rd != '0;
  assign stall   = ld_live && ((id_use1 && ex_rd == id_rs1) ||
                               (id_use2 && !id_store && ex_rd == id_rs2));

endmodule

module fwd_hazard_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] ex_rd,
  input logic [AW-1:0] mem_rd,
  input logic          mem_we,
  input logic          mem_load,
  input logic [AW-1:0] wb_rd,
  input logic          wb_we,
  input logic [DW-1:0] wb_data,
  input logic [DW-1:0] rd_data1,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          stall
);
  p_exmem_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b01) |-> !(mem_we && mem_rd == ex_rs1 && mem_rd != '0));
  p_zero_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b00 || fwd_b != 2'b00) |-> (fwd_a == 2'b00 || ex_rs1 != '0) && (fwd_b == 2'b00 || ex_rs2 != '0));
  p_zero_dst_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ex_rd != '0);
  p_no_load_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_load |-> (fwd_a != 2'b10 && fwd_b != 2'b10));
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_rd == id_rs1 && id_rs1 != '0) |-> rd_data1 == wb_data);
  p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |-> rd_data1 == '0);
  p_select_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a != 2'b11 && fwd_b != 2'b11);
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
  .ex_rd(ex_rd), .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load),
  .wb_rd(wb_rd), .wb_we(wb_we), .wb_data(wb_data), .rd_data1(rd_data1),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall)
);

// File: tb/fwd_hazard_unit_test.sv
`timescale 1ns/1ps
module fwd_hazard_unit_test;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_use1, id_use2, id_store, ex_we, ex_load, mem_we, mem_load, mem_store, wb_we, wb_load;
  logic [DW-1:0] wb_data, rd_data1, rd_data2;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, stall;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  fwd_hazard_unit #(.DW(DW), .NREG(32)) uut (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
    {id_use1, id_use2, id_store, ex_we, ex_load, mem_we, mem_load, mem_store, wb_we, wb_load} = '0;
    wb_data = '0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    step(); id_rs1 = 5; id_rs2 = 31; #1;
    chk("R11 reset read1", rd_data1, 0);
    chk("R11 reset read2", rd_data2, 0);
    chk("R11 reset fwd_a", {30'b0, fwd_a}, 0);
    chk("R11 reset stall", {31'b0, stall}, 0);
    idle();
  endtask

  task automatic t_exmem();
    step(); mem_we = 1; mem_rd = 3; ex_rs1 = 3; ex_rs2 = 4; #1;
    chk("R1 exmem fwd_a", {30'b0, fwd_a}, 2);
    chk("R1 unrelated fwd_b", {30'b0, fwd_b}, 0);
    ex_rs2 = 3; #1;
    chk("R1 exmem fwd_b", {30'b0, fwd_b}, 2);
    idle();
  endtask

  task automatic t_memwb();
    step(); wb_we = 1; wb_rd = 4; wb_data = 32'h1234; ex_rs2 = 4; id_rs1 = 4; #1;
    chk("R2 memwb fwd_b", {30'b0, fwd_b}, 1);
    chk("R5 same-cycle read with forward", rd_data1, 32'h1234);
    mem_we = 1; mem_rd = 4; #1;
    chk("R2 exmem priority", {30'b0, fwd_b}, 2);
    chk("R5 read unaffected by exmem", rd_data1, 32'h1234);
    mem_load = 1; #1;
    chk("R10 load in exmem not forwarded", {30'b0, fwd_b}, 0);
    idle();
  endtask

  task automatic t_zero();
    step(); mem_we = 1; mem_rd = 0; ex_rs1 = 0; wb_we = 1; wb_rd = 0; ex_rs2 = 0; #1;
    chk("R3 zero dst fwd_a", {30'b0, fwd_a}, 0);
    chk("R3 zero dst fwd_b", {30'b0, fwd_b}, 0);
    ex_load = 1; ex_we = 1; ex_rd = 0; id_rs1 = 0; id_use1 = 1; #1;
    chk("R3 zero dst stall", {31'b0, stall}, 0);
    mem_store = 1; mem_rs2 = 0; wb_load = 1; #1;
    chk("R3 zero dst st_fwd", {31'b0, st_fwd}, 0);
    idle();
  endtask

  task automatic t_we_off();
    step(); mem_rd = 8; ex_rs1 = 8; wb_rd = 9; ex_rs2 = 9; #1;
    chk("R4 exmem we off", {30'b0, fwd_a}, 0);
    chk("R4 memwb we off", {30'b0, fwd_b}, 0);
    idle();
  endtask

  task automatic t_regfile();
    step(); wb_we = 1; wb_rd = 7; wb_data = 32'hA5A5_0001; id_rs2 = 7; #1;
    chk("R5 bypass port2", rd_data2, 32'hA5A5_0001);
    step(); wb_we = 0; wb_data = 0; #1;
    chk("R11 value persists", rd_data2, 32'hA5A5_0001);
    wb_we = 1; wb_rd = 0; wb_data = 32'hFFFF_FFFF; id_rs1 = 0; #1;
    chk("R6 r0 during write", rd_data1, 0);
    step(); wb_we = 0; #1;
    chk("R6 r0 after write", rd_data1, 0);
    idle();
  endtask

  task automatic t_store();
    step(); mem_store = 1; mem_rs2 = 9; wb_we = 1; wb_load = 1; wb_rd = 9; #1;
    chk("R7 store data forward", {31'b0, st_fwd}, 1);
    wb_rd = 8; #1;
    chk("R7 mismatch no forward", {31'b0, st_fwd}, 0);
    wb_rd = 9; wb_load = 0; #1;
    chk("R7 non-load no store forward", {31'b0, st_fwd}, 0);
    idle();
  endtask

  task automatic t_loaduse();
    step(); ex_load = 1; ex_we = 1; ex_rd = 6; id_rs1 = 6; id_use1 = 1; #1;
    chk("R8 stall on rs1", {31'b0, stall}, 1);
    id_use1 = 0; #1;
    chk("R8 unused source no stall", {31'b0, stall}, 0);
    id_rs1 = 2; id_rs2 = 6; id_use2 = 1; #1;
    chk("R8 stall on rs2 alu", {31'b0, stall}, 1);
    id_store = 1; #1;
    chk("R9 store data no stall", {31'b0, stall}, 0);
    id_rs1 = 6; id_use1 = 1; #1;
    chk("R8 store address stall", {31'b0, stall}, 1);
    ex_load = 0; #1;
    chk("R8 non-load no stall", {31'b0, stall}, 0);
    idle();
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_exmem();
    t_memwb();
    t_zero();
    t_we_off();
    t_regfile();
    t_store();
    t_loaduse();
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule